// File: doc/BRIEF.md
# Programmable Supply Sequencing Engine

This block is a table-driven controller for board power sequencing. It keeps a current state number between 0 and 62. A configuration table holds one entry per state number. Each entry sets the pattern on ten drive-enable outputs and an interrupt level. It also holds three transition rules, each with its own target state:
- a sequence rule, which fires when selected status inputs match required values;
- a monitor rule, which fires when any selected status input leaves its healthy value;
- a timeout, counted in ticks spent in the state.

The status inputs carry the supply-fault and logic-input bits from the detectors. Transitions are evaluated only on cycles where the 10 µs timebase tick is high. This gives power-up ordering, power-down ordering and fault handling at tick granularity.

On each tick the engine makes one decision. Ordered from highest to lowest priority, the decisions are:
- FORCE: a software jump to a requested state.
- MON: the monitor rule fires.
- SEQ: the sequence rule fires.
- TMO: the timeout expires.
- COUNT: stay in the state and advance the tick counter.

A cycle without a tick is IDLE and changes nothing. Target number 63 is reserved and folds to state 0. This means a table entry or a software request can send the engine back to its start state. A software force request waits for the first tick at or after its cycle, overrides every rule, and restarts the timeout count even when the target is the current state. Software writes the table through a write port, one entry per cycle.

Top module: `seq_engine`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cur_state` is 0 and every table entry is cleared, so `drv_en` is 0 and `irq` is 0.
- R2: `drv_en` and `irq` always equal the drive and interrupt fields of the table entry of `cur_state`. A table write to that entry shows on them in the cycle after the write.
- R3: `cur_state` changes only at a clock edge where `tick` was high; a pending force request is also held until a tick.
- R4: The sequence rule fires when `cfg_seq_mask` is nonzero and every status bit selected by the mask equals the same bit of `cfg_seq_val`. It then moves to `cfg_seq_next` on the tick edge.
- R5: The monitor rule fires when any status bit selected by `cfg_mon_mask` differs from `cfg_mon_val`, and moves to `cfg_mon_next`. When both fire on the same tick, the monitor rule wins over the sequence rule.
- R6: With `cfg_tmo` = N, nonzero, and no other rule firing, the engine leaves for `cfg_tmo_next` on the Nth tick after entering the state. N = 0 disables the timeout. When the sequence rule fires on the tick where the timeout expires, the sequence rule wins.
- R7: A target of 63 from any rule or from a force request enters state 0, so `cur_state` never reads 63.
- R8: A force request (`force_valid` high for one cycle with `force_state`) is taken on the first tick at or after that cycle. It overrides all rules and restarts the timeout count from zero, also when the target is the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase pulse every 10 µs |
| status | input | 12 | Fault and logic bits from the detectors |
| force_valid | input | 1 | Software force request strobe |
| force_state | input | 6 | Requested state for the force |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 6 | Table entry to write (63 is dropped) |
| cfg_drv | input | 10 | Drive-enable pattern of the entry |
| cfg_irq | input | 1 | Interrupt level of the entry |
| cfg_seq_mask | input | 12 | Status bits the sequence rule looks at |
| cfg_seq_val | input | 12 | Required values for the sequence rule |
| cfg_seq_next | input | 6 | Sequence target |
| cfg_mon_mask | input | 12 | Status bits the monitor rule watches |
| cfg_mon_val | input | 12 | Healthy values for the monitor rule |
| cfg_mon_next | input | 6 | Monitor target |
| cfg_tmo | input | 16 | Timeout in ticks, 0 disables it |
| cfg_tmo_next | input | 6 | Timeout target |
| drv_en | output | 10 | Drive enables of the current state |
| irq | output | 1 | Interrupt level of the current state |
| cur_state | output | 6 | Current state number |

## Verification
Several rules can become due on the same tick, and the order of priority among them is the part of this block most likely to break. The bench enters a state with status bits that satisfy the sequence rule and trip the monitor in the same vector, and judges the result by which target `cur_state` holds afterwards. It also lets the timeout expire on the tick where the sequence condition turns true. Last, it issues a force request in a state whose monitor or timeout is due. For a same-state force, it counts the further ticks needed before the timeout fires, which shows whether the count restarted.

// File: rtl/seq_pkg.sv
package seq_pkg;

    parameter int SEQ_STATE_W = 6;
    parameter int SEQ_OUT_W   = 10;
    parameter int SEQ_IN_W    = 12;
    parameter int SEQ_TMO_W   = 16;

    localparam int SEQ_NUM_STATES = (1 << SEQ_STATE_W) - 1;

    typedef logic [SEQ_STATE_W-1:0] state_t;

    localparam state_t SEQ_RESERVED = '1;

    typedef struct packed {
        logic [SEQ_OUT_W-1:0] drv;
        logic                 irq;
        logic [SEQ_IN_W-1:0]  seq_mask;
        logic [SEQ_IN_W-1:0]  seq_val;
        state_t               seq_next;
        logic [SEQ_IN_W-1:0]  mon_mask;
        logic [SEQ_IN_W-1:0]  mon_val;
        state_t               mon_next;
        logic [SEQ_TMO_W-1:0] tmo;
        state_t               tmo_next;
    } entry_t;

    typedef enum logic [2:0] {
        DEC_IDLE,
        DEC_COUNT,
        DEC_FORCE,
        DEC_MON,
        DEC_SEQ,
        DEC_TMO
    } dec_e;

    function automatic state_t fold_state(input state_t s);
        return (s == SEQ_RESERVED) ? '0 : s;
    endfunction

endpackage

// File: rtl/seq_cfg_table.sv
module seq_cfg_table
    import seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we,
    input  state_t waddr,
    input  entry_t wdata,
    input  state_t raddr,
    output entry_t rdata
);

    entry_t mem_q [SEQ_NUM_STATES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEQ_NUM_STATES; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we && (waddr != SEQ_RESERVED)) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr != SEQ_RESERVED) begin
            rdata = mem_q[raddr];
        end
    end

endmodule

// File: rtl/seq_tmo_counter.sv
module seq_tmo_counter
    import seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [SEQ_TMO_W-1:0] limit,
    output logic                 expire
);

    logic [SEQ_TMO_W-1:0] cnt_q;
    logic [SEQ_TMO_W:0]   cnt_inc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != '1)) begin
            cnt_q <= cnt_inc[SEQ_TMO_W-1:0];
        end
    end

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        expire  = (limit != '0) && (cnt_inc >= {1'b0, limit});
    end

    // R8: every state entry or force restarts the count
    assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == '0));

endmodule

// File: rtl/seq_cond_eval.sv
module seq_cond_eval
    import seq_pkg::*;
(
    input  logic                entry_valid,
    input  entry_t              entry,
    input  logic [SEQ_IN_W-1:0] status,
    input  logic                tick,
    input  logic                tmo_expire,
    input  logic                force_now,
    input  state_t              force_tgt,
    output logic                mon_hit,
    output dec_e                dec,
    output state_t              next_state
);

    logic seq_hit;

    always_comb begin
        mon_hit = entry_valid && (|((status ^ entry.mon_val) & entry.mon_mask));
        seq_hit = entry_valid && (entry.seq_mask != '0) &&
                  (((status ^ entry.seq_val) & entry.seq_mask) == '0);

        if (!tick)           dec = DEC_IDLE;
        else if (force_now)  dec = DEC_FORCE;
        else if (mon_hit)    dec = DEC_MON;
        else if (seq_hit)    dec = DEC_SEQ;
        else if (tmo_expire) dec = DEC_TMO;
        else                 dec = DEC_COUNT;
    end

    always_comb begin
        next_state = '0;
        unique case (dec)
            DEC_IDLE:  next_state = '0;
            DEC_COUNT: next_state = '0;
            DEC_FORCE: next_state = fold_state(force_tgt);
            DEC_MON:   next_state = fold_state(entry.mon_next);
            DEC_SEQ:   next_state = fold_state(entry.seq_next);
            DEC_TMO:   next_state = fold_state(entry.tmo_next);
            default:   next_state = '0;
        endcase
    end

endmodule

// File: rtl/seq_engine.sv
module seq_engine
    import seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [SEQ_IN_W-1:0]    status,
    input  logic                   force_valid,
    input  logic [SEQ_STATE_W-1:0] force_state,
    input  logic                   cfg_we,
    input  logic [SEQ_STATE_W-1:0] cfg_addr,
    input  logic [SEQ_OUT_W-1:0]   cfg_drv,
    input  logic                   cfg_irq,
    input  logic [SEQ_IN_W-1:0]    cfg_seq_mask,
    input  logic [SEQ_IN_W-1:0]    cfg_seq_val,
    input  logic [SEQ_STATE_W-1:0] cfg_seq_next,
    input  logic [SEQ_IN_W-1:0]    cfg_mon_mask,
    input  logic [SEQ_IN_W-1:0]    cfg_mon_val,
    input  logic [SEQ_STATE_W-1:0] cfg_mon_next,
    input  logic [SEQ_TMO_W-1:0]   cfg_tmo,
    input  logic [SEQ_STATE_W-1:0] cfg_tmo_next,
    output logic [SEQ_OUT_W-1:0]   drv_en,
    output logic                   irq,
    output logic [SEQ_STATE_W-1:0] cur_state
);

    state_t state_q;
    logic   pend_q;
    state_t pend_state_q;
    logic   force_now;
    state_t force_tgt;
    entry_t wr_entry;
    entry_t cur_entry;
    logic   tmo_expire;
    logic   cnt_load;
    logic   mon_hit;
    dec_e   dec;
    state_t next_state;

    always_comb begin
        wr_entry.drv      = cfg_drv;
        wr_entry.irq      = cfg_irq;
        wr_entry.seq_mask = cfg_seq_mask;
        wr_entry.seq_val  = cfg_seq_val;
        wr_entry.seq_next = cfg_seq_next;
        wr_entry.mon_mask = cfg_mon_mask;
        wr_entry.mon_val  = cfg_mon_val;
        wr_entry.mon_next = cfg_mon_next;
        wr_entry.tmo      = cfg_tmo;
        wr_entry.tmo_next = cfg_tmo_next;
    end

    seq_cfg_table u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (wr_entry),
        .raddr (state_q),
        .rdata (cur_entry)
    );

    // Software force: held until a tick consumes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pend_state_q <= '0;
        end else if (tick) begin
            pend_q       <= 1'b0;
        end else if (force_valid) begin
            pend_q       <= 1'b1;
            pend_state_q <= force_state;
        end
    end

    always_comb begin
        force_now = force_valid || pend_q;
        force_tgt = force_valid ? force_state : pend_state_q;
    end

    seq_cond_eval u_eval (
        .entry_valid (1'b1),
        .entry       (cur_entry),
        .status      (status),
        .tick        (tick),
        .tmo_expire  (tmo_expire),
        .force_now   (force_now),
        .force_tgt   (force_tgt),
        .mon_hit     (mon_hit),
        .dec         (dec),
        .next_state  (next_state)
    );

    always_comb begin
        cnt_load = 1'b0;
        unique case (dec)
            DEC_IDLE:  cnt_load = 1'b0;
            DEC_COUNT: cnt_load = 1'b0;
            DEC_FORCE: cnt_load = 1'b1;
            DEC_MON:   cnt_load = 1'b1;
            DEC_SEQ:   cnt_load = 1'b1;
            DEC_TMO:   cnt_load = 1'b1;
            default:   cnt_load = 1'b0;
        endcase
    end

    seq_tmo_counter u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .load   (cnt_load),
        .limit  (cur_entry.tmo),
        .expire (tmo_expire)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (cnt_load) begin
            state_q <= next_state;
        end
    end

    // Outputs
    always_comb begin
        drv_en    = cur_entry.drv;
        irq       = cur_entry.irq;
        cur_state = state_q;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (state_q == '0));

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q));

    assert_mon_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !force_now && mon_hit) |=> (state_q == fold_state($past(cur_entry.mon_next))));

    assert_no_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != SEQ_RESERVED);

endmodule

// File: tb/tb_seq_engine.sv
module tb_seq_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic [11:0] status;
    logic        force_valid;
    logic [5:0]  force_state;
    logic        cfg_we;
    logic [5:0]  cfg_addr;
    logic [9:0]  cfg_drv;
    logic        cfg_irq;
    logic [11:0] cfg_seq_mask, cfg_seq_val, cfg_mon_mask, cfg_mon_val;
    logic [5:0]  cfg_seq_next, cfg_mon_next, cfg_tmo_next;
    logic [15:0] cfg_tmo;
    logic [9:0]  drv_en;
    logic        irq;
    logic [5:0]  cur_state;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_engine dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .status(status),
        .force_valid(force_valid), .force_state(force_state),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_drv(cfg_drv), .cfg_irq(cfg_irq),
        .cfg_seq_mask(cfg_seq_mask), .cfg_seq_val(cfg_seq_val), .cfg_seq_next(cfg_seq_next),
        .cfg_mon_mask(cfg_mon_mask), .cfg_mon_val(cfg_mon_val), .cfg_mon_next(cfg_mon_next),
        .cfg_tmo(cfg_tmo), .cfg_tmo_next(cfg_tmo_next),
        .drv_en(drv_en), .irq(irq), .cur_state(cur_state)
    );

    // {status[31:20], tick[19], force_valid[18], force_state[17:12], expected state[11:6], pad}
    localparam logic [31:0] VEC [NVEC] = '{
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd0, 6'd0},  // 0  R4 no match
        {12'h001, 1'b0, 1'b0, 6'd0,  6'd0, 6'd0},  // 1  R3 no tick
        {12'h001, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 2  R4
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 3  R6 count
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 4  R6 count
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd5, 6'd0},  // 5  R6 expire
        {12'h000, 1'b0, 1'b1, 6'd1,  6'd5, 6'd0},  // 6  R8 waits for tick
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 7  R8 pending taken
        {12'h002, 1'b1, 1'b0, 6'd0,  6'd2, 6'd0},  // 8  R4
        {12'h804, 1'b1, 1'b0, 6'd0,  6'd6, 6'd0},  // 9  R5 mon beats seq
        {12'h800, 1'b1, 1'b0, 6'd0,  6'd6, 6'd0},  // 10 R4 hold
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd0, 6'd0},  // 11 R7 target 63
        {12'h001, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 12 R4
        {12'h002, 1'b1, 1'b0, 6'd0,  6'd2, 6'd0},  // 13 R4
        {12'h00C, 1'b1, 1'b0, 6'd0,  6'd3, 6'd0},  // 14 R4
        {12'h004, 1'b1, 1'b0, 6'd0,  6'd4, 6'd0},  // 15 R4 match on low level
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd4, 6'd0},  // 16 R6
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd0, 6'd0},  // 17 R6
        {12'h001, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 18 R4
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 19 R6
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 20 R6
        {12'h002, 1'b1, 1'b0, 6'd0,  6'd2, 6'd0},  // 21 R6 seq beats timeout
        {12'h000, 1'b1, 1'b1, 6'd63, 6'd0, 6'd0},  // 22 R7 force 63
        {12'h001, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 23 R4
        {12'h800, 1'b1, 1'b1, 6'd2,  6'd2, 6'd0},  // 24 R8 force beats mon
        {12'h000, 1'b1, 1'b1, 6'd1,  6'd1, 6'd0},  // 25 R8
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 26 R6
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 27 R6
        {12'h000, 1'b1, 1'b1, 6'd1,  6'd1, 6'd0},  // 28 R8 same-state restart
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 29 R8
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd1, 6'd0},  // 30 R8
        {12'h000, 1'b1, 1'b0, 6'd0,  6'd5, 6'd0}   // 31 R8 expires after restart
    };

    function automatic logic [9:0] exp_drv(input logic [5:0] s);
        case (s)
            6'd1: return 10'h001;
            6'd2: return 10'h003;
            6'd3: return 10'h007;
            6'd4: return 10'h001;
            default: return 10'h000;
        endcase
    endfunction

    function automatic logic exp_irq(input logic [5:0] s);
        return (s == 6'd5) || (s == 6'd6);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cfg_state(input logic [5:0] a, input logic [9:0] d, input logic i,
                             input logic [11:0] sm, input logic [11:0] sv, input logic [5:0] sn,
                             input logic [11:0] mm, input logic [11:0] mv, input logic [5:0] mn,
                             input logic [15:0] t, input logic [5:0] tn);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_drv = d; cfg_irq = i;
        cfg_seq_mask = sm; cfg_seq_val = sv; cfg_seq_next = sn;
        cfg_mon_mask = mm; cfg_mon_val = mv; cfg_mon_next = mn;
        cfg_tmo = t; cfg_tmo_next = tn;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; status = '0; force_valid = 1'b0; force_state = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_drv = '0; cfg_irq = 1'b0;
        cfg_seq_mask = '0; cfg_seq_val = '0; cfg_seq_next = '0;
        cfg_mon_mask = '0; cfg_mon_val = '0; cfg_mon_next = '0;
        cfg_tmo = '0; cfg_tmo_next = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 state", 16'(cur_state), 16'd0);
        check("R1 drv", 16'(drv_en), 16'd0);
        check("R1 irq", 16'(irq), 16'd0);

        // state table: addr drv irq | seq mask val next | mon mask val next | tmo next
        cfg_state(6'd0, 10'h000, 1'b0, 12'h001, 12'h001, 6'd1, 12'h000, 12'h000, 6'd0, 16'd0, 6'd0);
        cfg_state(6'd1, 10'h001, 1'b0, 12'h002, 12'h002, 6'd2, 12'h800, 12'h000, 6'd6, 16'd3, 6'd5);
        cfg_state(6'd2, 10'h003, 1'b0, 12'h004, 12'h004, 6'd3, 12'h800, 12'h000, 6'd6, 16'd0, 6'd0);
        cfg_state(6'd3, 10'h007, 1'b0, 12'h008, 12'h000, 6'd4, 12'h800, 12'h000, 6'd6, 16'd0, 6'd0);
        cfg_state(6'd4, 10'h001, 1'b0, 12'h000, 12'h000, 6'd0, 12'h000, 12'h000, 6'd0, 16'd2, 6'd0);
        cfg_state(6'd5, 10'h000, 1'b1, 12'h000, 12'h000, 6'd0, 12'h000, 12'h000, 6'd0, 16'd0, 6'd0);
        cfg_state(6'd6, 10'h000, 1'b1, 12'h800, 12'h000, 6'd63, 12'h000, 12'h000, 6'd0, 16'd0, 6'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic [5:0] es;
            @(negedge clk);
            status      = VEC[i][31:20];
            tick        = VEC[i][19];
            force_valid = VEC[i][18];
            force_state = VEC[i][17:12];
            es          = VEC[i][11:6];
            @(posedge clk);
            #(CLK_PERIOD/4);
            check($sformatf("R3/R4/R5/R6/R7/R8 vector %0d state", i), 16'(cur_state), 16'(es));
            check($sformatf("R2 vector %0d drv", i), 16'(drv_en), 16'(exp_drv(es)));
            check($sformatf("R2 vector %0d irq", i), 16'(irq), 16'(exp_irq(es)));
            tick = 1'b0; force_valid = 1'b0;
        end

        // R2: rewriting the current entry reaches the outputs
        cfg_state(6'd5, 10'h3FF, 1'b0, 12'h000, 12'h000, 6'd0, 12'h000, 12'h000, 6'd0, 16'd0, 6'd0);
        check("R2 rewrite drv", 16'(drv_en), 16'h3FF);
        check("R2 rewrite irq", 16'(irq), 16'd0);
        check("R3 no tick during write", 16'(cur_state), 16'd5);

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mid-run state", 16'(cur_state), 16'd0);
        check("R1 mid-run drv", 16'(drv_en), 16'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule